// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Interlock

This block is the issue and hazard-control logic for an in-order pipeline with five stages: fetch, decode, operand fetch, execute and writeback. It carries one decoded instruction descriptor per stage. Each descriptor holds a tag, two source register indices with use flags, a destination index with a write enable, and a flag that marks a divide. Every cycle the block decides whether the instruction waiting in operand fetch may move on into execute.

Issue is refused in two cases. The first is a structural conflict: the single non-pipelined divider is still busy with an older divide. The second is a data conflict: a source register still has a write pending from an older instruction. While issue is refused, the three front stages hold and execute receives a bubble. A taken branch that resolves in execute flushes fetch, decode and operand fetch in the same cycle, and a flush overrides a stall.

The surrounding datapath sees the result on the valid bit of each stage. It sees `stall_o`, which also means the offered input was not taken, and `flush_o`. It also sees the tag now in execute.

Top module: `pipe_interlock`

## Requirements
- R1: After reset all five stage valid bits, `stall_o` and `flush_o` are 0.
- R2: Without hazards, an input accepted at clock edge k (in_valid_i high, stall_o and flush_o low before that edge) shows in execute after edge k+3, and each stage valid bit follows the one before it; five back-to-back inputs fill all five stages.
- R3: An instruction in operand fetch whose used source matches the destination of an older writer still pending (write bit set at issue, cleared when that writer leaves execute) raises `stall_o`; issued back to back, the dependent instruction enters execute one edge late.
- R4: A divide may enter execute no sooner than DIV_LAT+1 edges after the previous divide entered; a non-divide is not delayed by the divider.
- R5: In a stall cycle, fetch, decode and operand fetch hold, the input is not consumed, and stage_vld_o[3] is 0 after the next edge.
- R6: br_taken_i high while execute is valid raises `flush_o` in that cycle; after the next edge stage_vld_o is 5'b10000 and the flushed instructions never enter execute.
- R7: When a flush and a hazard coincide, `flush_o` is 1 and `stall_o` is 0.
- R8: br_taken_i has no effect while execute is empty: `flush_o` stays 0 and the stages advance normally.
- R9: A source whose use flag is 0, or an older instruction whose write enable is 0, causes no stall.
- R10: Tags enter execute in the order the instructions were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A new instruction is offered to fetch |
| in_tag_i | input | TAG_W | Tag of the offered instruction |
| in_rs1_i | input | clog2(NREG) | First source register index |
| in_rs1_use_i | input | 1 | First source is read |
| in_rs2_i | input | clog2(NREG) | Second source register index |
| in_rs2_use_i | input | 1 | Second source is read |
| in_rd_i | input | clog2(NREG) | Destination register index |
| in_rd_wen_i | input | 1 | Destination is written |
| in_div_i | input | 1 | Instruction needs the divider |
| br_taken_i | input | 1 | Branch in execute is taken |
| stage_vld_o | output | 5 | Valid per stage, bit 0 fetch to bit 4 writeback |
| stall_o | output | 1 | Operand fetch held, input not accepted |
| flush_o | output | 1 | Front three stages cleared at next edge |
| ex_tag_o | output | TAG_W | Tag of the instruction in execute |

## Verification
The bench drives inputs on the falling edge. It reads `stall_o` and `flush_o` 1 ns later, because both are combinational in the current state and in `br_taken_i`. The registered outputs are read on the next falling edge, after the edge that updates them. An input accepted at edge k is expected in execute after edge k+3. A RAW hit adds one edge, and a divide is pushed out to DIV_LAT+1 edges after the previous divide. A stall or flush seen in one cycle is checked against the stage valid bits one edge later. The sweeps cover every destination and source pair, both source slots, the use and write-enable flags and short gaps between instructions. The expected execute edge is computed from that formula for each case.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
  localparam int NSTAGE = 5;
  localparam int ST_IF  = 0;
  localparam int ST_ID  = 1;
  localparam int ST_OF  = 2;
  localparam int ST_EX  = 3;
  localparam int ST_WB  = 4;
endpackage

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  input  logic         hold_i,
  input  logic         kill_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      dat_o <= '0;
    end else if (kill_i) begin
      vld_o <= 1'b0;
    end else if (!hold_i) begin
      vld_o <= vld_i;
      dat_o <= dat_i;
    end
  end
endmodule

// File: rtl/pipe_scoreboard.sv
module pipe_scoreboard #(
  parameter int NREG = 16,
  localparam int RW = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [RW-1:0] set_idx_i,
  input  logic          clr_i,
  input  logic [RW-1:0] clr_idx_i,
  input  logic [RW-1:0] rs1_i,
  input  logic          rs1_use_i,
  input  logic [RW-1:0] rs2_i,
  input  logic          rs2_use_i,
  output logic          hit_o
);
  logic [NREG-1:0] pend_q;

  for (genvar r = 0; r < NREG; r++) begin : g_bit
    // a new writer wins over the retiring one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 pend_q[r] <= 1'b0;
      else if (set_i && set_idx_i == RW'(r))       pend_q[r] <= 1'b1;
      else if (clr_i && clr_idx_i == RW'(r))       pend_q[r] <= 1'b0;
    end
  end

  assign hit_o = (rs1_use_i && pend_q[rs1_i]) || (rs2_use_i && pend_q[rs2_i]);
endmodule

// File: rtl/pipe_unit_busy.sv
module pipe_unit_busy #(
  parameter int LAT = 3,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CW'(LAT);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pipe_pkg::*;
#(
  parameter int NREG    = 16,
  parameter int DIV_LAT = 3,
  parameter int TAG_W   = 4,
  localparam int RW     = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  input  logic [RW-1:0]     in_rs1_i,
  input  logic              in_rs1_use_i,
  input  logic [RW-1:0]     in_rs2_i,
  input  logic              in_rs2_use_i,
  input  logic [RW-1:0]     in_rd_i,
  input  logic              in_rd_wen_i,
  input  logic              in_div_i,
  input  logic              br_taken_i,
  output logic [NSTAGE-1:0] stage_vld_o,
  output logic              stall_o,
  output logic              flush_o,
  output logic [TAG_W-1:0]  ex_tag_o
);
  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [RW-1:0]    rs1;
    logic             use1;
    logic [RW-1:0]    rs2;
    logic             use2;
    logic [RW-1:0]    rd;
    logic             wen;
    logic             div;
  } desc_t;
  localparam int DW = $bits(desc_t);

  logic [NSTAGE-1:0] vld_q, in_v, hold, kill;
  desc_t             st_q [NSTAGE];
  desc_t             st_d [NSTAGE];

  logic raw_hit, div_busy, hazard, flush, stall, issue;

  // named views for the checker
  logic [RW-1:0] of_rs1, of_rs2, ex_rd;
  logic          of_use1, of_use2, ex_wen, ex_div;

  assign of_rs1  = st_q[ST_OF].rs1;
  assign of_use1 = st_q[ST_OF].use1;
  assign of_rs2  = st_q[ST_OF].rs2;
  assign of_use2 = st_q[ST_OF].use2;
  assign ex_rd   = st_q[ST_EX].rd;
  assign ex_wen  = st_q[ST_EX].wen;
  assign ex_div  = st_q[ST_EX].div;

  assign flush  = br_taken_i && vld_q[ST_EX];
  assign hazard = vld_q[ST_OF] && (raw_hit || (st_q[ST_OF].div && div_busy));
  assign stall  = hazard && !flush;
  assign issue  = vld_q[ST_OF] && !hazard && !flush;

  always_comb begin
    in_v[ST_IF] = in_valid_i;
    st_d[ST_IF] = '{tag: in_tag_i, rs1: in_rs1_i, use1: in_rs1_use_i,
                    rs2: in_rs2_i, use2: in_rs2_use_i, rd: in_rd_i,
                    wen: in_rd_wen_i, div: in_div_i};
    for (int s = 1; s < NSTAGE; s++) begin
      in_v[s] = vld_q[s-1];
      st_d[s] = st_q[s-1];
    end
    in_v[ST_EX] = issue;
    for (int s = 0; s < NSTAGE; s++) begin
      hold[s] = (s <= ST_OF) ? stall : 1'b0;
      kill[s] = (s <= ST_OF) ? flush : 1'b0;
    end
  end

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    pipe_stage_reg #(.W(DW)) u_st (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .vld_i  (in_v[s]),
      .dat_i  (st_d[s]),
      .hold_i (hold[s]),
      .kill_i (kill[s]),
      .vld_o  (vld_q[s]),
      .dat_o  (st_q[s])
    );
  end

  pipe_scoreboard #(.NREG(NREG)) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (issue && st_q[ST_OF].wen),
    .set_idx_i (st_q[ST_OF].rd),
    .clr_i     (vld_q[ST_EX] && ex_wen),
    .clr_idx_i (ex_rd),
    .rs1_i     (of_rs1),
    .rs1_use_i (of_use1),
    .rs2_i     (of_rs2),
    .rs2_use_i (of_use2),
    .hit_o     (raw_hit)
  );

  pipe_unit_busy #(.LAT(DIV_LAT)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (issue && st_q[ST_OF].div),
    .busy_o  (div_busy)
  );

  assign stage_vld_o = vld_q;
  assign stall_o     = stall;
  assign flush_o     = flush;
  assign ex_tag_o    = st_q[ST_EX].tag;
endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk #(
  parameter int DIV_LAT = 3,
  parameter int RW      = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [4:0]    stage_vld_o,
  input logic          stall_o,
  input logic          flush_o,
  input logic [RW-1:0] of_rs1,
  input logic          of_use1,
  input logic [RW-1:0] of_rs2,
  input logic          of_use2,
  input logic [RW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_div
);
  localparam int GW = $clog2(DIV_LAT + 2) + 1;
  logic [GW-1:0] gap_q;

  // edges since the last divide entered execute, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               gap_q <= GW'(DIV_LAT + 1);
    else if (stage_vld_o[3] && ex_div)         gap_q <= GW'(1);
    else if (gap_q <= GW'(DIV_LAT))            gap_q <= gap_q + 1'b1;
  end

  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !flush_o) |=> (stage_vld_o[2:1] == $past(stage_vld_o[1:0])));

  a_r2_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (stage_vld_o[4] == $past(stage_vld_o[3])));

  a_r3_raw_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld_o[2] && stage_vld_o[3] && ex_wen && !flush_o &&
     ((of_use1 && of_rs1 == ex_rd) || (of_use2 && of_rs2 == ex_rd))) |-> stall_o);

  a_r4_div_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_vld_o[3] && ex_div) |-> (gap_q > GW'(DIV_LAT)));

  a_r5_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stage_vld_o[3]);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> (stage_vld_o[2:0] == $past(stage_vld_o[2:0])));

  a_r6_flush_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (stage_vld_o == 5'b10000));
endmodule

bind pipe_interlock pipe_interlock_chk #(.DIV_LAT(DIV_LAT), .RW(RW)) u_chk (.*);

// File: tb/sim_pipe_interlock.sv
`timescale 1ns/1ps
module sim_pipe_interlock;
  localparam int NREG = 4, RW = 2, DIV_LAT = 2, TAG_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 0, in_rs1_use_i = 0, in_rs2_use_i = 0, in_rd_wen_i = 0, in_div_i = 0;
  logic br_taken_i = 0;
  logic [TAG_W-1:0] in_tag_i = '0;
  logic [RW-1:0] in_rs1_i = '0, in_rs2_i = '0, in_rd_i = '0;
  logic [4:0] stage_vld_o;
  logic stall_o, flush_o;
  logic [TAG_W-1:0] ex_tag_o;

  pipe_interlock #(.NREG(NREG), .DIV_LAT(DIV_LAT), .TAG_W(TAG_W)) u0 (.*, .clk_i(clk));

  always #4 clk = ~clk;

  typedef struct { bit v; int rs1; bit u1; int rs2; bit u2; int rd; bit w; bit dv; } item_t;
  item_t prog [8];
  int total = 0, bad = 0, cyc = 0, last_tag = 0;
  int ex_cyc [16];
  int acc_cyc [16];
  bit stall_seen = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      if (stall_seen) chk(!stage_vld_o[3], "R5 bubble after stall", stage_vld_o[3], 0);
      if (stage_vld_o[3]) begin
        chk(int'(ex_tag_o) > last_tag, "R10 order", ex_tag_o, last_tag + 1);
        last_tag = ex_tag_o;
        ex_cyc[ex_tag_o] = cyc;
      end
    end
  end

  task automatic clear_rec();
    last_tag = 0;
    for (int i = 0; i < 16; i++) begin ex_cyc[i] = -1; acc_cyc[i] = -1; end
  endtask

  function automatic item_t mk(bit v, int rs1, bit u1, int rs2, bit u2, int rd, bit w, bit dv);
    item_t it;
    it.v = v; it.rs1 = rs1; it.u1 = u1; it.rs2 = rs2; it.u2 = u2; it.rd = rd; it.w = w; it.dv = dv;
    return it;
  endfunction

  task automatic drive(input item_t it, input int tag);
    in_valid_i = it.v; in_tag_i = TAG_W'(tag);
    in_rs1_i = RW'(it.rs1); in_rs1_use_i = it.u1;
    in_rs2_i = RW'(it.rs2); in_rs2_use_i = it.u2;
    in_rd_i = RW'(it.rd); in_rd_wen_i = it.w; in_div_i = it.dv;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid_i = 0; br_taken_i = 0;
      #1 stall_seen = stall_o;
    end
  endtask

  task automatic feed(input int n);
    int idx = 0;
    while (idx < n) begin
      @(negedge clk);
      drive(prog[idx], idx + 1);
      #1;
      stall_seen = stall_o;
      if (!stall_o && !flush_o) begin
        if (prog[idx].v) acc_cyc[idx + 1] = cyc + 1;
        idx++;
      end
    end
    idx = 0;
    idle(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_rec();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(stage_vld_o == 5'b0, "R1 valid after reset", stage_vld_o, 0);
    chk(!stall_o && !flush_o, "R1 stall/flush after reset", {stall_o, flush_o}, 0);

    // R2 fill
    clear_rec();
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      drive(mk(1, 0, 0, 0, 0, k % 4, 1, 0), k);
    end
    @(negedge clk);
    in_valid_i = 0;
    chk(stage_vld_o == 5'b11111, "R2 pipeline full", stage_vld_o, 31);
    idle(8);

    // R3 R9 R2: RAW sweep
    for (int rd = 0; rd < NREG; rd++)
      for (int rs = 0; rs < NREG; rs++)
        for (int g = 0; g < 3; g++)
          for (int u = 0; u < 2; u++)
            for (int w = 0; w < 2; w++)
              for (int s = 0; s < 2; s++) begin
                bit haz;
                int exp;
                clear_rec();
                prog[0] = mk(1, 0, 0, 0, 0, rd, w[0], 0);
                for (int i = 1; i <= g; i++) prog[i] = mk(0, 0, 0, 0, 0, 0, 0, 0);
                if (s == 0) prog[g + 1] = mk(1, rs, u[0], rd, 0, 0, 0, 0);
                else        prog[g + 1] = mk(1, rd, 0, rs, u[0], 0, 0, 0);
                feed(g + 2);
                haz = (w == 1) && (u == 1) && (rs == rd) && (g == 0);
                exp = ex_cyc[1] + 1 + g + (haz ? 1 : 0);
                chk(ex_cyc[1] == acc_cyc[1] + 3, "R2 latency to execute", ex_cyc[1] - acc_cyc[1], 3);
                chk(ex_cyc[g + 2] == exp, haz ? "R3 raw delay" : "R9 no false stall",
                    ex_cyc[g + 2] - ex_cyc[1], exp - ex_cyc[1]);
              end

    // R4 divider spacing
    for (int g = 0; g < 5; g++)
      for (int d2 = 0; d2 < 2; d2++) begin
        int exp;
        clear_rec();
        prog[0] = mk(1, 0, 0, 0, 0, 0, 0, 1);
        for (int i = 1; i <= g; i++) prog[i] = mk(0, 0, 0, 0, 0, 0, 0, 0);
        prog[g + 1] = mk(1, 0, 0, 0, 0, 0, 0, d2[0]);
        feed(g + 2);
        exp = 1 + g;
        if (d2 == 1 && exp < DIV_LAT + 1) exp = DIV_LAT + 1;
        chk(ex_cyc[g + 2] - ex_cyc[1] == exp, "R4 divider spacing", ex_cyc[g + 2] - ex_cyc[1], exp);
      end

    // R6 flush
    clear_rec();
    stall_seen = 0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      drive(mk(1, 0, 0, 0, 0, 0, 0, 0), k);
    end
    @(negedge clk);
    chk(stage_vld_o == 5'b01111 && ex_tag_o == 1, "R6 setup", stage_vld_o, 15);
    drive(mk(1, 0, 0, 0, 0, 0, 0, 0), 5);
    br_taken_i = 1;
    #1;
    chk(flush_o == 1'b1, "R6 flush raised", flush_o, 1);
    @(negedge clk);
    br_taken_i = 0; in_valid_i = 0;
    chk(stage_vld_o == 5'b10000, "R6 front cleared", stage_vld_o, 16);
    idle(8);
    for (int t = 2; t <= 5; t++)
      chk(ex_cyc[t] == -1, "R6 flushed never executes", ex_cyc[t], -1);

    // R7 flush over stall
    clear_rec();
    @(negedge clk); drive(mk(1, 0, 0, 0, 0, 1, 1, 0), 1);
    @(negedge clk); drive(mk(1, 1, 1, 0, 0, 0, 0, 0), 2);
    @(negedge clk); in_valid_i = 0;
    @(negedge clk);
    @(negedge clk);
    chk(stage_vld_o == 5'b01100, "R7 setup", stage_vld_o, 12);
    #1;
    chk(stall_o == 1'b1, "R3 stall raised", stall_o, 1);
    br_taken_i = 1;
    #1;
    chk(flush_o && !stall_o, "R7 flush wins", {flush_o, stall_o}, 2);
    @(negedge clk);
    br_taken_i = 0;
    chk(stage_vld_o == 5'b10000, "R7 operand fetch cleared", stage_vld_o, 16);
    idle(8);

    // R8 branch ignored with empty execute
    clear_rec();
    @(negedge clk); drive(mk(1, 0, 0, 0, 0, 0, 0, 0), 1);
    @(negedge clk);
    in_valid_i = 0; br_taken_i = 1;
    #1;
    chk(flush_o == 1'b0, "R8 no flush", flush_o, 0);
    @(negedge clk);
    br_taken_i = 0;
    chk(stage_vld_o == 5'b00010, "R8 stages advance", stage_vld_o, 2);
    idle(8);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule